// File: doc/BRIEF.md
# Prioritised interrupt arbiter with claim and complete

This block sits between a set of external interrupt sources and a set of target contexts. A context is one privilege level on one hardware thread. The gateways in front of the block hand it one-cycle request pulses, which it holds as pending bits. Software programs the following through a plain register write port:

- a priority for each source;
- an enable bit for each pairing of context and source;
- a threshold for each context.

For every context the block continuously finds the best source that is eligible for it. It raises that context's interrupt line when the winner's priority clears the context's threshold.

A context services an interrupt in two steps. First it issues a claim. The claim returns the winning source ID, clears that source's pending bit and marks the source as in service. An in-service source takes no further part in arbitration for any context. Later the context writes the same ID back as a completion, which releases the source. Source ID 0 is reserved and means "nothing to claim".

Contexts can be declared absent at build time. An absent context never interrupts and never claims anything.

The claim response carries no back-pressure. A claim is a single-cycle request, and its answer is presented for exactly one cycle on the following cycle. The requester must take it in that cycle.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, every interrupt line and `claim_vld` are low, and all priorities, pending bits, in-service bits, enables and thresholds are zero. A claim made at this point therefore returns ID 0.
- R2: A source is eligible for a context when all four of these hold: it is pending, it is not in service, it is enabled for that context, and its priority is nonzero. A source with priority 0 is never delivered and never claimed.
- R3: Among the sources eligible for a context, the one with the highest priority wins. When priorities tie, the lower source ID wins.
- R4: A context's interrupt line is high only when its winner's priority is strictly greater than the context's threshold. A priority equal to or below the threshold keeps the line low.
- R5: A claim (`claim_req` high with `claim_ctx`) returns the winner for that context on the next cycle, with `claim_vld` high, and does not consider the threshold. In the same step it clears that source's pending bit and sets its in-service bit.
- R6: A claim that finds no eligible source returns ID 0 with `claim_vld` high and changes no state.
- R7: An in-service source is excluded from arbitration until it is completed. A gateway pulse that arrives meanwhile is kept as pending, and the source is delivered again once it is released.
- R8: A completion (`cmp_we`, `cmp_ctx`, `cmp_id`) releases the source only if that source is enabled for that context. Otherwise the completion is ignored and the source stays in service.
- R9: An absent context never asserts its interrupt line. Its claims return 0 and leave the pending state untouched.
- R10: Enables are independent per context. A source enabled for one context neither interrupts nor can be claimed by another context that has not enabled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | NSRC | Gateway request pulses; bit i is source ID i+1 |
| prio_we | input | 1 | Priority write strobe |
| prio_id | input | ID_W | Source ID whose priority is written |
| prio_val | input | PRIO_W | Priority value (0 = never delivered) |
| en_we | input | 1 | Enable write strobe |
| en_ctx | input | CTX_W | Context whose enable is written |
| en_id | input | ID_W | Source ID whose enable is written |
| en_val | input | 1 | New enable bit |
| thr_we | input | 1 | Threshold write strobe |
| thr_ctx | input | CTX_W | Context whose threshold is written |
| thr_val | input | PRIO_W | New threshold |
| claim_req | input | 1 | Claim request, one cycle per claim |
| claim_ctx | input | CTX_W | Claiming context |
| claim_vld | output | 1 | Claim answer valid, one cycle after the request |
| claim_id | output | ID_W | Claimed source ID, 0 when nothing was claimable |
| cmp_we | input | 1 | Completion strobe |
| cmp_ctx | input | CTX_W | Completing context |
| cmp_id | input | ID_W | Source ID being released |
| irq | output | NCTX | Registered interrupt line per context |

## Verification
Every register in the block updates on the clock edge that samples its input. Each interrupt line is computed from those registers and registered again. So an interrupt line answers a priority, enable, threshold, claim or completion write two edges after the write is driven, and it answers a gateway pulse after the same two edges. A claim answer appears on the first edge after the request. The bench drives every input on a falling edge and reads the claim answer at the following falling edge. For an interrupt line it waits one further falling edge. It also checks the line at the intermediate falling edge, to show that the line has not moved early. The ignored-completion and absent-context cases are judged by what a later interrupt line or claim reveals about the in-service and pending state.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Width of a source ID able to hold 0..nsrc
  function automatic int id_width(input int nsrc);
    return $clog2(nsrc + 1);
  endfunction
  // Width of a context selector
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NSRC   = 10,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prio_we,
  input  logic [ID_W-1:0]        prio_id,
  input  logic [PRIO_W-1:0]      prio_val,
  input  logic [NSRC-1:0]        set_vec,
  input  logic [NSRC-1:0]        clr_vec,
  input  logic [NSRC-1:0]        done_vec,
  output logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic [NSRC-1:0]        pend_q,
  output logic [NSRC-1:0]        insvc_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [PRIO_W-1:0] prio_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_q     <= '0;
        pend_q[i]  <= 1'b0;
        insvc_q[i] <= 1'b0;
      end else begin
        if (prio_we && prio_id == ID_W'(i + 1)) prio_q <= prio_val;
        // a new gateway pulse survives a same-cycle claim
        pend_q[i]  <= (pend_q[i] & ~clr_vec[i]) | set_vec[i];
        insvc_q[i] <= (insvc_q[i] & ~done_vec[i]) | clr_vec[i];
      end
    end

    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q;

    // R5: a claim pops the pending bit and marks the source in service
    a_r5_claim_pops: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[i] && !set_vec[i] |=> insvc_q[i] && !pend_q[i]);

    // R8: service ends only through an accepted completion
    a_r8_release_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(insvc_q[i]) |-> $past(done_vec[i]));
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC   = 10,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4
) (
  input  logic [NSRC-1:0]        cand,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic [ID_W-1:0]        best_id,
  output logic [PRIO_W-1:0]      best_prio
);
  // Linear scan: strict greater-than keeps the lower ID on a tie,
  // and starting from 0 keeps priority-0 sources out.
  always_comb begin
    best_id   = '0;
    best_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && prio_flat[i*PRIO_W +: PRIO_W] > best_prio) begin
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
        best_id   = ID_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/irq_ctx_unit.sv
module irq_ctx_unit #(
  parameter int NSRC    = 10,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4,
  parameter bit PRESENT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_we,
  input  logic [ID_W-1:0]        en_id,
  input  logic                   en_val,
  input  logic                   thr_we,
  input  logic [PRIO_W-1:0]      thr_val,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC-1:0]        insvc,
  output logic [NSRC-1:0]        en_q,
  output logic [ID_W-1:0]        best_id,
  output logic                   irq_q
);
  logic [PRIO_W-1:0] thr_q;
  logic [NSRC-1:0]   active;
  logic [ID_W-1:0]   pick_id;
  logic [PRIO_W-1:0] pick_prio;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      thr_q <= '0;
    end else begin
      if (thr_we) thr_q <= thr_val;
      for (int i = 0; i < NSRC; i++)
        if (en_we && en_id == ID_W'(i + 1)) en_q[i] <= en_val;
    end
  end

  assign active = pend & ~insvc & en_q;

  irq_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
    .cand(active), .prio_flat(prio_flat),
    .best_id(pick_id), .best_prio(pick_prio)
  );

  assign best_id = PRESENT ? pick_id : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= PRESENT && (pick_id != '0) && (pick_prio > thr_q);
  end

  // R4: a maximal threshold can never be exceeded
  a_r4_max_thr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q == '1 |=> !irq_q);

  // R3: the picked source is really a candidate here
  a_r3_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    pick_id != '0 |-> active[pick_id - ID_W'(1)]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSRC   = 10,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter logic [NCTX-1:0] CTX_PRESENT = '1,
  localparam int ID_W  = id_width(NSRC),
  localparam int CTX_W = sel_width(NCTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_pulse,
  input  logic              prio_we,
  input  logic [ID_W-1:0]   prio_id,
  input  logic [PRIO_W-1:0] prio_val,
  input  logic              en_we,
  input  logic [CTX_W-1:0]  en_ctx,
  input  logic [ID_W-1:0]   en_id,
  input  logic              en_val,
  input  logic              thr_we,
  input  logic [CTX_W-1:0]  thr_ctx,
  input  logic [PRIO_W-1:0] thr_val,
  input  logic              claim_req,
  input  logic [CTX_W-1:0]  claim_ctx,
  output logic              claim_vld,
  output logic [ID_W-1:0]   claim_id,
  input  logic              cmp_we,
  input  logic [CTX_W-1:0]  cmp_ctx,
  input  logic [ID_W-1:0]   cmp_id,
  output logic [NCTX-1:0]   irq
);
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NSRC-1:0]        pend, insvc, clr_vec, done_vec;
  logic [NSRC-1:0]        en_vecs  [NCTX];
  logic [ID_W-1:0]        best_ids [NCTX];
  logic [ID_W-1:0]        sel_id;

  irq_src_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .prio_we(prio_we), .prio_id(prio_id), .prio_val(prio_val),
    .set_vec(src_pulse), .clr_vec(clr_vec), .done_vec(done_vec),
    .prio_flat(prio_flat), .pend_q(pend), .insvc_q(insvc)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    irq_ctx_unit #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W),
                   .PRESENT(CTX_PRESENT[c])) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .en_we(en_we && en_ctx == CTX_W'(c)), .en_id(en_id), .en_val(en_val),
      .thr_we(thr_we && thr_ctx == CTX_W'(c)), .thr_val(thr_val),
      .prio_flat(prio_flat), .pend(pend), .insvc(insvc),
      .en_q(en_vecs[c]), .best_id(best_ids[c]), .irq_q(irq[c])
    );
  end

  // claim selection and completion decode
  always_comb begin
    sel_id   = '0;
    clr_vec  = '0;
    done_vec = '0;
    if (int'(claim_ctx) < NCTX) sel_id = best_ids[claim_ctx];
    for (int i = 0; i < NSRC; i++) begin
      if (claim_req && sel_id == ID_W'(i + 1)) clr_vec[i] = 1'b1;
      if (cmp_we && int'(cmp_ctx) < NCTX && cmp_id == ID_W'(i + 1) &&
          en_vecs[cmp_ctx][i])
        done_vec[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim_vld <= 1'b0;
      claim_id  <= '0;
    end else begin
      claim_vld <= claim_req;
      claim_id  <= claim_req ? sel_id : '0;
    end
  end

  // R5: a returned ID is in service when it is presented
  a_r5_claimed_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    claim_vld && claim_id != '0 |-> insvc[claim_id - ID_W'(1)]);
endmodule

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
  localparam int NSRC = 10, NCTX = 3, PRIO_W = 3, ID_W = 4, CTX_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src_pulse = '0;
  logic prio_we = 0, en_we = 0, en_val = 0, thr_we = 0, claim_req = 0, cmp_we = 0;
  logic [ID_W-1:0] prio_id = '0, en_id = '0, cmp_id = '0;
  logic [PRIO_W-1:0] prio_val = '0, thr_val = '0;
  logic [CTX_W-1:0] en_ctx = '0, thr_ctx = '0, claim_ctx = '0, cmp_ctx = '0;
  logic claim_vld;
  logic [ID_W-1:0] claim_id;
  logic [NCTX-1:0] irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_arbiter #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W),
                .CTX_PRESENT(3'b011)) u0 (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .prio_we(prio_we), .prio_id(prio_id), .prio_val(prio_val),
    .en_we(en_we), .en_ctx(en_ctx), .en_id(en_id), .en_val(en_val),
    .thr_we(thr_we), .thr_ctx(thr_ctx), .thr_val(thr_val),
    .claim_req(claim_req), .claim_ctx(claim_ctx),
    .claim_vld(claim_vld), .claim_id(claim_id),
    .cmp_we(cmp_we), .cmp_ctx(cmp_ctx), .cmp_id(cmp_id), .irq(irq)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_prio(input int id, input int v);
    prio_we = 1; prio_id = ID_W'(id); prio_val = PRIO_W'(v); step(); prio_we = 0;
  endtask
  task automatic wr_en(input int c, input int id, input bit v);
    en_we = 1; en_ctx = CTX_W'(c); en_id = ID_W'(id); en_val = v; step(); en_we = 0;
  endtask
  task automatic wr_thr(input int c, input int v);
    thr_we = 1; thr_ctx = CTX_W'(c); thr_val = PRIO_W'(v); step(); thr_we = 0;
  endtask
  task automatic pulse(input logic [NSRC-1:0] m);
    src_pulse = m; step(); src_pulse = '0;
  endtask
  task automatic claim(input int c, input int exp, input string tag);
    claim_req = 1; claim_ctx = CTX_W'(c); step(); claim_req = 0;
    check(int'(claim_vld), 1, {tag, " claim_vld"});
    check(int'(claim_id), exp, {tag, " claim_id"});
  endtask
  task automatic complete(input int c, input int id);
    cmp_we = 1; cmp_ctx = CTX_W'(c); cmp_id = ID_W'(id); step(); cmp_we = 0;
  endtask

  task automatic t_reset();
    check(int'(irq), 0, "R1 irq after reset");
    check(int'(claim_vld), 0, "R1 claim_vld after reset");
    claim(0, 0, "R1 claim on empty");
  endtask

  task automatic t_basic();
    wr_prio(3, 2); wr_en(0, 3, 1);
    pulse(10'b0000000100);
    check(int'(irq[0]), 0, "R2 irq not yet at first edge");
    step();
    check(int'(irq[0]), 1, "R2 irq after pending");
    check(int'(irq[1]), 0, "R10 other context quiet");
  endtask

  task automatic t_threshold();
    wr_thr(0, 2); step();
    check(int'(irq[0]), 0, "R4 equal threshold blocks");
    wr_thr(0, 1); step();
    check(int'(irq[0]), 1, "R4 above threshold passes");
    wr_thr(0, 7); step();
    check(int'(irq[0]), 0, "R4 high threshold blocks");
    claim(0, 3, "R5 claim ignores threshold");
    complete(0, 3);
    wr_thr(0, 0); step();
  endtask

  task automatic t_service();
    pulse(10'b0000000100); step();
    check(int'(irq[0]), 1, "R2 re-pending delivered");
    claim(0, 3, "R5 claim winner");
    step();
    check(int'(irq[0]), 0, "R5 irq drops after claim");
    pulse(10'b0000000100); step();
    check(int'(irq[0]), 0, "R7 in-service source held off");
    claim(0, 0, "R6 nothing claimable");
    complete(1, 3); step();
    check(int'(irq[0]), 0, "R8 completion from non-enabled context ignored");
    complete(0, 3); step();
    check(int'(irq[0]), 1, "R7 latched pending after release");
    claim(0, 3, "R7 reclaim");
    complete(0, 3);
  endtask

  task automatic t_priority();
    wr_prio(4, 5); wr_prio(6, 5); wr_prio(2, 1);
    wr_en(0, 2, 1); wr_en(0, 4, 1); wr_en(0, 5, 1); wr_en(0, 6, 1);
    pulse(10'b0000111110); step();
    check(int'(irq[0]), 1, "R3 irq with several pending");
    claim(0, 4, "R3 highest then lowest id");
    claim(0, 6, "R3 tie partner");
    claim(0, 3, "R3 next priority");
    claim(0, 2, "R3 lowest priority");
    claim(0, 0, "R2 priority 0 never claimed");
    step();
    check(int'(irq[0]), 0, "R2 priority 0 never delivered");
    complete(0, 4); complete(0, 6); complete(0, 3); complete(0, 2);
  endtask

  task automatic t_context();
    wr_prio(7, 3); wr_en(1, 7, 1);
    pulse(10'b0001000000); step();
    check(int'(irq[1]), 1, "R10 enabled context raised");
    check(int'(irq[0]), 0, "R10 non-enabled context quiet");
    claim(0, 0, "R10 non-enabled context cannot claim");
    claim(1, 7, "R10 enabled context claims");
    complete(1, 7);
  endtask

  task automatic t_absent();
    wr_prio(8, 4); wr_en(2, 8, 1);
    pulse(10'b0010000000); step();
    check(int'(irq[2]), 0, "R9 absent context no irq");
    claim(2, 0, "R9 absent context claims nothing");
    wr_en(0, 8, 1); step();
    check(int'(irq[0]), 1, "R6 pending kept after empty claim");
    claim(0, 8, "R9 pending untouched by absent claim");
    complete(0, 8);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_threshold();
    t_service();
    t_priority();
    t_context();
    t_absent();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule